// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block turns single read or write requests from a processor-style core into external bus cycles on a pin group that carries the address and then the data. A request holds a 20-bit physical address, a memory-or-port select, an upper-byte enable and up to 16 bits of write data. The address covers 1 MB of memory or 64 K ports. Each cycle moves through four phases, T1 to T4, with any number of wait phases before T4. In T1 the shared pins carry the address and a latch pulse marks it valid. From T2 the shared pins turn around for data, and the upper four address lines change to status bits. A slow target holds the ready input low to stretch the cycle.

The core offers a request with a valid/accept handshake. Only one cycle can be in flight. Read data comes back together with a one-clock done pulse. An external master can ask for the bus with a hold input. The sequencer first finishes any cycle it has started. It then raises an acknowledge and drops the output enables of its pins, so that the pad ring can float them. Lowering the hold request returns the bus in two steps: the acknowledge falls first, and the pins are driven again one clock later.

Top module: `mxbus_seq`

## Requirements
- R1: After reset the block is idle. The latch pulse is 0, both strobes and the data enable are 1, the acknowledge is 0, the pin enable is 1, the data-pin enable is 0 and the request accept is 1.
- R2: In the clock after a request is accepted (T1), the outputs are set as follows. `ale`=1 and `ad_oe`=1. `ad_o` carries address bits [15:0] and `hi_o` carries address bits [19:16]. `io_sel` is 0 for a memory access and 1 for a port access. `bhe_n` is the inverse of the byte-high enable. Both strobes stay 1 in T1.
- R3: A read cycle behaves as follows. In T2, T3 and every wait phase: `rd_n`=0, `wr_n`=1, `dir_tx`=0, `den_n`=0 and `ad_oe`=0. In T4, `rd_n` returns to 1. The two strobes are never low together.
- R4: A write cycle behaves as follows. In T2, T3 and every wait phase: `wr_n`=0, `rd_n`=1 and `dir_tx`=1. From T2 through T4, `ad_oe`=1, `ad_o` equals the write data and `den_n`=0.
- R5: From T2 through T4, `hi_o` carries the status field. Bit 0 is the write flag, bit 1 is the port-access flag, and bits 3:2 are 0.
- R6: `ready_in` is sampled only at the ends of T3 and of each wait phase. Each low sample adds one wait phase, so a cycle with N low samples lasts 4+N clocks. A low `ready_in` during T1 or T2 has no effect.
- R7: For a read, the block samples `ad_i` at the edge that ends the last T3 or wait phase. It presents that value on `rsp_rdata` with `rsp_done`=1 for exactly the one T4 clock.
- R8: `req_ready` is 0 from T1 through T4 and while the bus is handed over. A `req_valid` offered while `req_ready` is 0 starts no cycle.
- R9: A hold request that arrives during a cycle does not shorten it. `hold_ack` rises in the clock after T4. While `hold_ack` is 1, `bus_oe`=0 and `ad_oe`=0.
- R10: `hold_ack` falls one clock after `hold_req` is sampled low. `bus_oe` stays 0 for that clock and returns to 1 on the next one.
- R11: When the block is idle and a hold request and a core request arrive together, the hold request wins. No latch pulse appears and `hold_ack` rises on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core offers a request |
| req_ready | output | 1 | Request accepted this clock |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = port access, 0 = memory |
| req_bhe | input | 1 | Upper data byte enable |
| req_addr | input | 20 | Physical address |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | Cycle completion pulse (T4) |
| rsp_rdata | output | 16 | Read data |
| ad_o | output | 16 | Shared address/data pins, output value |
| ad_oe | output | 1 | Shared pins output enable |
| ad_i | input | 16 | Shared address/data pins, input value |
| hi_o | output | 4 | Upper address / status lines |
| ale | output | 1 | Address latch pulse |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_sel | output | 1 | Memory (0) or port (1) select |
| bhe_n | output | 1 | Upper byte enable, active low |
| dir_tx | output | 1 | Transceiver direction, 0 = receive |
| den_n | output | 1 | Transceiver enable, active low |
| bus_oe | output | 1 | Enable for address, data and control pins |
| ready_in | input | 1 | Target ready, low inserts wait phases |
| hold_req | input | 1 | External master bus request |
| hold_ack | output | 1 | Bus granted to external master |

## Verification
The bench builds the block with its default widths: a 20-bit address and a 16-bit data path, which leave a 4-bit upper field. It sweeps every combination of read or write, memory or port, and byte-high enable, against zero to three wait phases. Addresses and data are derived arithmetically from the loop index, so every bit of the shared pins and of the upper field toggles. This covers every phase sequence the sequencer can take. Separate runs cover a hold request raised in the middle of a cycle, a hold request that collides with a core request while the block is idle, requests offered while the block is busy, and a low ready input outside the sampling phases.

// File: rtl/mxbus_pkg.sv
package mxbus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_TW   = 3'd4,
    PH_T4   = 3'd5,
    PH_HOLD = 3'd6,
    PH_REL  = 3'd7
  } phase_t;

  // Strobe phases: the transfer is in flight
  function automatic logic ph_active(input phase_t p);
    return (p == PH_T2) || (p == PH_T3) || (p == PH_TW);
  endfunction

  // Phases where ready is sampled
  function automatic logic ph_sample(input phase_t p);
    return (p == PH_T3) || (p == PH_TW);
  endfunction

endpackage

// File: rtl/mxbus_rst_sync.sv
module mxbus_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = shreg[STAGES-1];
endmodule

// File: rtl/mxbus_phase_fsm.sv
module mxbus_phase_fsm
  import mxbus_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   hold_req,
  input  logic   ready_in,
  output phase_t phase
);
  phase_t phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (hold_req)   phase_d = PH_HOLD;
        else if (start) phase_d = PH_T1;
      end
      PH_T1:   phase_d = PH_T2;
      PH_T2:   phase_d = PH_T3;
      PH_T3,
      PH_TW:   phase_d = ready_in ? PH_T4 : PH_TW;
      PH_T4:   phase_d = hold_req ? PH_HOLD : PH_IDLE;
      PH_HOLD: phase_d = hold_req ? PH_HOLD : PH_REL;
      PH_REL:  phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  assign phase = phase_q;
endmodule

// File: rtl/mxbus_req_store.sv
module mxbus_req_store
  import mxbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              req_write,
  input  logic              req_io,
  input  logic              req_bhe,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  phase_t            phase,
  input  logic              ready_in,
  input  logic [DATA_W-1:0] ad_i,
  output logic              q_write,
  output logic              q_io,
  output logic              q_bhe,
  output logic [ADDR_W-1:0] q_addr,
  output logic [DATA_W-1:0] q_wdata,
  output logic [DATA_W-1:0] rdata
);
  logic              cap_en;
  logic              rd_en;
  logic              w_d, io_d, bhe_d;
  logic [ADDR_W-1:0] a_d;
  logic [DATA_W-1:0] wd_d, rd_d;

  assign cap_en = start;
  assign rd_en  = ph_sample(phase) && ready_in && !q_write;

  always_comb begin
    w_d   = q_write;
    io_d  = q_io;
    bhe_d = q_bhe;
    a_d   = q_addr;
    wd_d  = q_wdata;
    if (cap_en) begin
      w_d   = req_write;
      io_d  = req_io;
      bhe_d = req_bhe;
      a_d   = req_addr;
      wd_d  = req_wdata;
    end
    rd_d = rd_en ? ad_i : rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_write <= 1'b0;
      q_io    <= 1'b0;
      q_bhe   <= 1'b0;
      q_addr  <= '0;
      q_wdata <= '0;
      rdata   <= '0;
    end else begin
      q_write <= w_d;
      q_io    <= io_d;
      q_bhe   <= bhe_d;
      q_addr  <= a_d;
      q_wdata <= wd_d;
      rdata   <= rd_d;
    end
  end
endmodule

// File: rtl/mxbus_pin_drive.sv
module mxbus_pin_drive
  import mxbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  phase_t            phase,
  input  logic              q_write,
  input  logic              q_io,
  input  logic              q_bhe,
  input  logic [ADDR_W-1:0] q_addr,
  input  logic [DATA_W-1:0] q_wdata,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe,
  output logic [ADDR_W-DATA_W-1:0] hi_o,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              io_sel,
  output logic              bhe_n,
  output logic              dir_tx,
  output logic              den_n,
  output logic              bus_oe
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic [HI_W-1:0] status;
  logic            is_t1, act, mid, in_cyc;

  // Status field: bit0 write, bit1 port access, rest zero
  for (genvar g = 0; g < HI_W; g++) begin : g_status
    if (g == 0)      begin : g_w  assign status[g] = q_write; end
    else if (g == 1) begin : g_io assign status[g] = q_io;    end
    else             begin : g_z  assign status[g] = 1'b0;    end
  end

  always_comb begin
    is_t1  = (phase == PH_T1);
    act    = ph_active(phase);
    mid    = act || (phase == PH_T4);
    in_cyc = is_t1 || mid;

    ale    = is_t1;
    ad_oe  = is_t1 || (q_write && mid);
    ad_o   = is_t1 ? q_addr[DATA_W-1:0] : (mid ? q_wdata : '0);
    hi_o   = is_t1 ? q_addr[ADDR_W-1:DATA_W] : (mid ? status : '0);
    rd_n   = !(act && !q_write);
    wr_n   = !(act && q_write);
    io_sel = in_cyc && q_io;
    bhe_n  = !(in_cyc && q_bhe);
    dir_tx = in_cyc && q_write;
    den_n  = !(q_write ? mid : act);
    bus_oe = !((phase == PH_HOLD) || (phase == PH_REL));
  end
endmodule

// File: rtl/mxbus_seq.sv
module mxbus_seq
  import mxbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_io,
  input  logic              req_bhe,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe,
  input  logic [DATA_W-1:0] ad_i,
  output logic [ADDR_W-DATA_W-1:0] hi_o,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              io_sel,
  output logic              bhe_n,
  output logic              dir_tx,
  output logic              den_n,
  output logic              bus_oe,
  input  logic              ready_in,
  input  logic              hold_req,
  output logic              hold_ack
);
  logic              rst_n_s;
  phase_t            phase;
  logic              start;
  logic              q_write, q_io, q_bhe;
  logic [ADDR_W-1:0] q_addr;
  logic [DATA_W-1:0] q_wdata;

  mxbus_rst_sync #(.STAGES(2)) rst_i (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  assign req_ready = (phase == PH_IDLE) && !hold_req;
  assign start     = req_valid && req_ready;
  assign rsp_done  = (phase == PH_T4);
  assign hold_ack  = (phase == PH_HOLD);

  mxbus_phase_fsm fsm_i (
    .clk(clk), .rst_n(rst_n_s), .start(start), .hold_req(hold_req),
    .ready_in(ready_in), .phase(phase)
  );

  mxbus_req_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) store_i (
    .clk(clk), .rst_n(rst_n_s), .start(start),
    .req_write(req_write), .req_io(req_io), .req_bhe(req_bhe),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .phase(phase), .ready_in(ready_in), .ad_i(ad_i),
    .q_write(q_write), .q_io(q_io), .q_bhe(q_bhe),
    .q_addr(q_addr), .q_wdata(q_wdata), .rdata(rsp_rdata)
  );

  mxbus_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) drive_i (
    .phase(phase), .q_write(q_write), .q_io(q_io), .q_bhe(q_bhe),
    .q_addr(q_addr), .q_wdata(q_wdata),
    .ad_o(ad_o), .ad_oe(ad_oe), .hi_o(hi_o), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n), .io_sel(io_sel), .bhe_n(bhe_n),
    .dir_tx(dir_tx), .den_n(den_n), .bus_oe(bus_oe)
  );
endmodule

// File: rtl/mxbus_seq_chk.sv
module mxbus_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic rsp_done,
  input logic ad_oe,
  input logic ale,
  input logic rd_n,
  input logic wr_n,
  input logic bus_oe,
  input logic hold_ack
);
  a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  a_r2_ale_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (rd_n && wr_n && ad_oe));

  a_r3_read_pins_released: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  a_r8_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && ale));

  a_r7_done_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> ($past(!rd_n || !wr_n) && rd_n && wr_n));

  a_r9_hold_floats: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack |-> (!bus_oe && !ad_oe && !req_ready));

  a_r10_ack_before_drive: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_ack) |-> !bus_oe);
endmodule

bind mxbus_seq mxbus_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_done(rsp_done), .ad_oe(ad_oe), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
  .bus_oe(bus_oe), .hold_ack(hold_ack)
);

// File: tb/mxbus_seq_tb_top.sv
module mxbus_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write, req_io, req_bhe;
  logic [19:0] req_addr;
  logic [15:0] req_wdata, rsp_rdata, ad_o, ad_i;
  logic        rsp_done, ad_oe, ale, rd_n, wr_n, io_sel, bhe_n;
  logic        dir_tx, den_n, bus_oe, ready_in, hold_req, hold_ack;
  logic [3:0]  hi_o;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mxbus_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_io(req_io), .req_bhe(req_bhe),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_done(rsp_done),
    .rsp_rdata(rsp_rdata), .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i),
    .hi_o(hi_o), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .io_sel(io_sel),
    .bhe_n(bhe_n), .dir_tx(dir_tx), .den_n(den_n), .bus_oe(bus_oe),
    .ready_in(ready_in), .hold_req(hold_req), .hold_ack(hold_ack)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Runs one cycle; inputs change and outputs are sampled at negedge
  task automatic run_cycle(input bit w, input bit io, input bit bhe,
                           input logic [19:0] a, input logic [15:0] wd,
                           input logic [15:0] rdv, input int waits,
                           input bit stray, input bit hold_mid);
    logic [3:0] st;
    st = {2'b00, io, w};
    @(negedge clk);
    req_valid = 1; req_write = w; req_io = io; req_bhe = bhe;
    req_addr = a; req_wdata = wd; ready_in = 0;
    chk("R8 accept when idle", req_ready, 1);
    @(negedge clk);                                   // T1
    req_valid = stray; req_addr = ~a;
    chk("R2 ale", ale, 1);
    chk("R2 ad_oe", ad_oe, 1);
    chk("R2 low address", ad_o, a[15:0]);
    chk("R2 high address", hi_o, a[19:16]);
    chk("R2 io_sel", io_sel, io);
    chk("R2 bhe_n", bhe_n, !bhe);
    chk("R2 strobes idle", {rd_n, wr_n}, 2'b11);
    chk("R8 busy", req_ready, 0);
    @(negedge clk);                                   // T2, ready low here is ignored (R6)
    if (hold_mid) hold_req = 1;
    ad_i = rdv;
    for (int k = 0; k <= waits; k++) begin
      // T2 on k==0 is checked first, then each T3/Tw
      if (k == 0) begin
        chk("R3/R4 T2 rd_n", rd_n, w);
        chk("R3/R4 T2 wr_n", wr_n, !w);
        chk("R5 status T2", hi_o, st);
        @(negedge clk);                               // T3
      end
      ready_in = (k == waits);
      chk("R6 strobe held in T3/Tw", {rd_n, wr_n}, w ? 2'b10 : 2'b01);
      chk("R3/R4 dir_tx", dir_tx, w);
      chk("R3/R4 den_n", den_n, 0);
      chk("R3/R4 ad_oe", ad_oe, w);
      if (w) chk("R4 write data", ad_o, wd);
      chk("R5 status Tw", hi_o, st);
      chk("R8 busy no start", {req_ready, ale}, 2'b00);
      chk("R9 no early ack", hold_ack, 0);
      @(negedge clk);
    end
    req_valid = 0;                                    // T4
    chk("R6 T4 reached", rsp_done, 1);
    chk("R3/R4 strobes released", {rd_n, wr_n}, 2'b11);
    chk("R4 den in T4", den_n, !w);
    chk("R5 status T4", hi_o, st);
    if (!w) chk("R7 read data", rsp_rdata, rdv);
    else    chk("R4 data held T4", ad_o, wd);
    chk("R9 bus kept through T4", bus_oe, 1);
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_io = 0; req_bhe = 0;
    req_addr = '0; req_wdata = '0; ad_i = '0; ready_in = 1; hold_req = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 ale", ale, 0);
    chk("R1 strobes/den", {rd_n, wr_n, den_n}, 3'b111);
    chk("R1 hold_ack", hold_ack, 0);
    chk("R1 bus_oe", bus_oe, 1);
    chk("R1 ad_oe", ad_oe, 0);
    chk("R1 req_ready", req_ready, 1);

    // Sweep: direction x space x byte enable x waits
    for (int i = 0; i < 32; i++) begin
      logic [19:0] a;
      logic [15:0] wd, rv;
      a  = 20'h5A5A5 ^ 20'(i * 32'h2F1B7);
      wd = 16'hC33C ^ 16'(i * 32'h0913);
      rv = 16'h3CC3 + 16'(i * 32'h1D45);
      run_cycle(i[0], i[1], i[2], a, wd, rv, i / 8, i[3], 1'b0);
      @(negedge clk);
      chk("R8 stray request ignored", ale, 0);
    end

    // Hold raised mid-cycle: cycle completes first
    run_cycle(1'b0, 1'b0, 1'b1, 20'hABCDE, 16'h1111, 16'hBEEF, 2, 1'b0, 1'b1);
    @(negedge clk);
    chk("R9 ack after T4", hold_ack, 1);
    chk("R9 pins floated", {bus_oe, ad_oe}, 2'b00);
    req_valid = 1; req_addr = 20'h12345;
    @(negedge clk);
    chk("R9 still held", hold_ack, 1);
    chk("R8 no start in hold", {req_ready, ale}, 2'b00);
    hold_req = 0;
    @(negedge clk);
    chk("R10 ack released", hold_ack, 0);
    chk("R10 pins still floated", bus_oe, 0);
    req_valid = 0;
    @(negedge clk);
    chk("R10 pins driven again", bus_oe, 1);
    chk("R10 idle no cycle", ale, 0);

    // Idle collision: hold wins
    req_valid = 1; hold_req = 1;
    @(negedge clk);
    chk("R11 hold wins", {hold_ack, ale}, 2'b10);
    req_valid = 0; hold_req = 0;
    repeat (2) @(negedge clk);
    chk("R11 bus returned", {bus_oe, hold_ack}, 2'b10);
    done_flag = 1;
  end

  initial begin
    fork
      wait (done_flag);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule